// File: doc/BRIEF.md
# Command-Driven AXI4 Burst Transfer Engine

This block turns simple transfer requests into single AXI4 memory bursts. It has two halves that share no state. The store half takes a byte address and a beat count. It moves that many words from a valid/ready input stream onto the AXI4 address and write-data channels, then waits for the write response. The fetch half takes a byte address and a beat count. It issues one AXI4 read burst and hands the returned beats to a valid/ready output stream, marking the final beat.

Each half signals its state through its request-ready line. Ready is high while the half is idle. It falls in the cycle after a request is accepted. It rises again only once the whole burst is finished: for a store, the write response has been taken; for a fetch, the final beat has left through the output stream. A requester can therefore treat the rising edge of ready as a commit point.

The requester must align every address to the word size and must keep every burst inside one 4 KB page. The block does not split bursts, does not retry, and carries neither narrow nor unaligned transfers.

Top module: `burst_dma_master`

## Requirements
- R1: While rst_n is low, both request-ready outputs are high, and m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready and rd_out_valid are all low.
- R2: A half accepts a request only on a clock edge where its request-valid and request-ready are both high. Its request-ready is low in the following cycle. A request presented while that half is busy is ignored, and it issues no address beat.
- R3: For an accepted store request, the address beat carries m_awaddr equal to the request address and m_awlen equal to the request count. It also carries m_awsize equal to log2 of the word width in bytes (3 for 64-bit words) and m_awburst = 2'b01 (incrementing). m_awvalid and the address fields hold steady until m_awready.
- R4: A store moves exactly count+1 input-stream words to the write-data channel, unchanged and in order. Every beat has m_wstrb all ones, and m_wlast is high only on the beat whose zero-based index equals the count. The transfer tolerates stalls on either side at any beat.
- R5: m_bready is high only after the address beat and the last data beat have both been accepted. Store request-ready stays low until the write response handshake and is high in the cycle after it.
- R6: For an accepted fetch request, the address beat carries m_araddr equal to the request address, m_arlen equal to the count, m_arsize equal to log2 of the word width in bytes, and m_arburst = 2'b01. m_arvalid and these fields hold steady until m_arready.
- R7: A fetch delivers count+1 read beats to the output stream, unchanged and in order. m_rready follows rd_out_ready only while beats are being fetched. rd_out_last is high only on the beat whose zero-based index equals the count.
- R8: Fetch request-ready stays low until the output handshake of the final beat and is high in the cycle after it.
- R9: The store and fetch halves can hold requests in flight at the same time, and neither one stalls or alters the other.
- R10: A count of 0 moves a single beat marked last. The largest count, 2^CNT_W-1, moves 2^CNT_W beats in one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd_addr | input | ADDR_W | Store request byte address, word aligned |
| wr_cmd_len | input | CNT_W | Store request beat count minus one |
| wr_cmd_valid | input | 1 | Store request present |
| wr_cmd_ready | output | 1 | Store half idle; rises when a burst is committed |
| wr_in_data | input | DATA_W | Input stream word |
| wr_in_valid | input | 1 | Input stream word valid |
| wr_in_ready | output | 1 | Input stream word taken |
| rd_cmd_addr | input | ADDR_W | Fetch request byte address, word aligned |
| rd_cmd_len | input | CNT_W | Fetch request beat count minus one |
| rd_cmd_valid | input | 1 | Fetch request present |
| rd_cmd_ready | output | 1 | Fetch half idle; rises when the last beat has left |
| rd_out_data | output | DATA_W | Output stream word |
| rd_out_last | output | 1 | Final beat of the fetch burst |
| rd_out_valid | output | 1 | Output stream word valid |
| rd_out_ready | input | 1 | Output stream consumer ready |
| m_awaddr | output | ADDR_W | AXI4 write address |
| m_awlen | output | 8 | AXI4 write burst length minus one |
| m_awsize | output | 3 | AXI4 write beat size code |
| m_awburst | output | 2 | AXI4 write burst type |
| m_awvalid | output | 1 | AXI4 write address valid |
| m_awready | input | 1 | AXI4 write address ready |
| m_wdata | output | DATA_W | AXI4 write data |
| m_wstrb | output | DATA_W/8 | AXI4 write byte strobes |
| m_wlast | output | 1 | AXI4 last write beat |
| m_wvalid | output | 1 | AXI4 write data valid |
| m_wready | input | 1 | AXI4 write data ready |
| m_bvalid | input | 1 | AXI4 write response valid |
| m_bready | output | 1 | AXI4 write response ready |
| m_araddr | output | ADDR_W | AXI4 read address |
| m_arlen | output | 8 | AXI4 read burst length minus one |
| m_arsize | output | 3 | AXI4 read beat size code |
| m_arburst | output | 2 | AXI4 read burst type |
| m_arvalid | output | 1 | AXI4 read address valid |
| m_arready | input | 1 | AXI4 read address ready |
| m_rdata | input | DATA_W | AXI4 read data |
| m_rvalid | input | 1 | AXI4 read data valid |
| m_rready | output | 1 | AXI4 read data ready |

## Verification
The assertions check the handshake rules on every cycle. Ready must fall after an accept. Address beats must hold while stalled. No write-data beat may follow the last one. The response ready must stay low while idle, and ready must return right after the response or the final output beat. Data order, the exact beat count, the last-beat position, the address fields and the rejection of requests made while busy can only be shown by the bench's scenarios. These include stalled channels, single-beat and full-length bursts, and store and fetch in flight together, with every beat compared against a queue of expected words.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Burst type code for incrementing bursts
  localparam logic [1:0] BURST_INCR = 2'b01;

  // AXI4 length field width
  localparam int unsigned AXLEN_W = 8;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_XFER = 2'd1,
    WR_RESP = 2'd2
  } wr_state_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_DATA = 2'd2
  } rd_state_e;

endpackage

// File: rtl/dma_beat_ctr.sv
// Counts accepted beats of one burst and flags the beat whose index
// equals the programmed count.
module dma_beat_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             at_last
);

  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] idx_n;
  logic             idx_en;

  always_comb begin
    idx_en = clr | adv;
    idx_n  = clr ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_n;
    end
  end

  assign at_last = (idx_q == limit);

endmodule

// File: rtl/dma_wr_engine.sv
// Store half: one request becomes one AXI4 write burst fed by a stream.
module dma_wr_engine
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [CNT_W-1:0]     cmd_len,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [ADDR_W-1:0]    awaddr,
  output logic [AXLEN_W-1:0]   awlen,
  output logic [2:0]           awsize,
  output logic [1:0]           awburst,
  output logic                 awvalid,
  input  logic                 awready,
  output logic [DATA_W-1:0]    wdata,
  output logic [DATA_W/8-1:0]  wstrb,
  output logic                 wlast,
  output logic                 wvalid,
  input  logic                 wready,
  input  logic                 bvalid,
  output logic                 bready
);

  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam logic [2:0]  SIZE_CODE = 3'($clog2(STRB_W));

  wr_state_e         state_q, state_n;
  logic              aw_done_q, aw_done_n;
  logic              w_done_q, w_done_n;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic              ld_en;
  logic              w_open;
  logic              w_fire;
  logic              beat_last;

  // Channel decode from registered state
  always_comb begin
    cmd_ready = (state_q == WR_IDLE);
    awvalid   = (state_q == WR_XFER) && !aw_done_q;
    w_open    = (state_q == WR_XFER) && !w_done_q;
    wvalid    = w_open && in_valid;
    in_ready  = w_open && wready;
    w_fire    = wvalid && wready;
    bready    = (state_q == WR_RESP);
  end

  // Next-state logic
  always_comb begin
    state_n   = state_q;
    aw_done_n = aw_done_q;
    w_done_n  = w_done_q;
    ld_en     = 1'b0;
    unique case (state_q)
      WR_IDLE: begin
        if (cmd_valid) begin
          ld_en     = 1'b1;
          aw_done_n = 1'b0;
          w_done_n  = 1'b0;
          state_n   = WR_XFER;
        end
      end
      WR_XFER: begin
        if (awvalid && awready) begin
          aw_done_n = 1'b1;
        end
        if (w_fire && beat_last) begin
          w_done_n = 1'b1;
        end
        if (aw_done_n && w_done_n) begin
          state_n = WR_RESP;
        end
      end
      WR_RESP: begin
        if (bvalid) begin
          state_n = WR_IDLE;
        end
      end
      default: state_n = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WR_IDLE;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      aw_done_q <= aw_done_n;
      w_done_q  <= w_done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (ld_en) begin
      addr_q <= cmd_addr;
      len_q  <= cmd_len;
    end
  end

  dma_beat_ctr #(
    .CNT_W (CNT_W)
  ) wbeat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ld_en),
    .adv     (w_fire),
    .limit   (len_q),
    .at_last (beat_last)
  );

  assign awaddr  = addr_q;
  assign awlen   = AXLEN_W'(len_q);
  assign awsize  = SIZE_CODE;
  assign awburst = BURST_INCR;
  assign wdata   = in_data;
  assign wstrb   = {STRB_W{1'b1}};
  assign wlast   = beat_last;

endmodule

// File: rtl/dma_rd_engine.sv
// Fetch half: one request becomes one AXI4 read burst drained to a stream.
module dma_rd_engine
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [CNT_W-1:0]   cmd_len,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  araddr,
  output logic [AXLEN_W-1:0] arlen,
  output logic [2:0]         arsize,
  output logic [1:0]         arburst,
  output logic               arvalid,
  input  logic               arready,
  input  logic [DATA_W-1:0]  rdata,
  input  logic               rvalid,
  output logic               rready
);

  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam logic [2:0]  SIZE_CODE = 3'($clog2(STRB_W));

  rd_state_e         state_q, state_n;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic              ld_en;
  logic              in_data_ph;
  logic              r_fire;
  logic              beat_last;

  always_comb begin
    cmd_ready  = (state_q == RD_IDLE);
    arvalid    = (state_q == RD_ADDR);
    in_data_ph = (state_q == RD_DATA);
    out_valid  = in_data_ph && rvalid;
    rready     = in_data_ph && out_ready;
    r_fire     = rvalid && rready;
    out_last   = in_data_ph && beat_last;
  end

  always_comb begin
    state_n = state_q;
    ld_en   = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (cmd_valid) begin
          ld_en   = 1'b1;
          state_n = RD_ADDR;
        end
      end
      RD_ADDR: begin
        if (arready) begin
          state_n = RD_DATA;
        end
      end
      RD_DATA: begin
        if (r_fire && beat_last) begin
          state_n = RD_IDLE;
        end
      end
      default: state_n = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (ld_en) begin
      addr_q <= cmd_addr;
      len_q  <= cmd_len;
    end
  end

  dma_beat_ctr #(
    .CNT_W (CNT_W)
  ) rbeat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ld_en),
    .adv     (r_fire),
    .limit   (len_q),
    .at_last (beat_last)
  );

  assign araddr   = addr_q;
  assign arlen    = AXLEN_W'(len_q);
  assign arsize   = SIZE_CODE;
  assign arburst  = BURST_INCR;
  assign out_data = rdata;

endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   wr_cmd_addr,
  input  logic [CNT_W-1:0]    wr_cmd_len,
  input  logic                wr_cmd_valid,
  output logic                wr_cmd_ready,
  input  logic [DATA_W-1:0]   wr_in_data,
  input  logic                wr_in_valid,
  output logic                wr_in_ready,
  input  logic [ADDR_W-1:0]   rd_cmd_addr,
  input  logic [CNT_W-1:0]    rd_cmd_len,
  input  logic                rd_cmd_valid,
  output logic                rd_cmd_ready,
  output logic [DATA_W-1:0]   rd_out_data,
  output logic                rd_out_last,
  output logic                rd_out_valid,
  input  logic                rd_out_ready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic                m_rvalid,
  output logic                m_rready
);

  dma_wr_engine #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) wr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_addr  (wr_cmd_addr),
    .cmd_len   (wr_cmd_len),
    .cmd_valid (wr_cmd_valid),
    .cmd_ready (wr_cmd_ready),
    .in_data   (wr_in_data),
    .in_valid  (wr_in_valid),
    .in_ready  (wr_in_ready),
    .awaddr    (m_awaddr),
    .awlen     (m_awlen),
    .awsize    (m_awsize),
    .awburst   (m_awburst),
    .awvalid   (m_awvalid),
    .awready   (m_awready),
    .wdata     (m_wdata),
    .wstrb     (m_wstrb),
    .wlast     (m_wlast),
    .wvalid    (m_wvalid),
    .wready    (m_wready),
    .bvalid    (m_bvalid),
    .bready    (m_bready)
  );

  dma_rd_engine #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_addr  (rd_cmd_addr),
    .cmd_len   (rd_cmd_len),
    .cmd_valid (rd_cmd_valid),
    .cmd_ready (rd_cmd_ready),
    .out_data  (rd_out_data),
    .out_last  (rd_out_last),
    .out_valid (rd_out_valid),
    .out_ready (rd_out_ready),
    .araddr    (m_araddr),
    .arlen     (m_arlen),
    .arsize    (m_arsize),
    .arburst   (m_arburst),
    .arvalid   (m_arvalid),
    .arready   (m_arready),
    .rdata     (m_rdata),
    .rvalid    (m_rvalid),
    .rready    (m_rready)
  );

endmodule

// File: rtl/dma_master_chk.sv
module dma_master_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cmd_valid,
  input logic              wr_cmd_ready,
  input logic              rd_cmd_valid,
  input logic              rd_cmd_ready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rready,
  input logic              rd_out_valid,
  input logic              rd_out_ready,
  input logic              rd_out_last
);

  // R2
  wr_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid && wr_cmd_ready |=> !wr_cmd_ready);

  // R2
  rd_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid && rd_cmd_ready |=> !rd_cmd_ready);

  // R3
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  // R6
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

  // R4
  w_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid);

  // R5
  bready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_ready |-> !m_bready);

  // R5
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid && m_bready |=> wr_cmd_ready);

  // R7
  rready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_ready |-> !m_rready && !rd_out_valid);

  // R8
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && rd_out_ready && rd_out_last |=> rd_cmd_ready);

endmodule

bind burst_dma_master dma_master_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_dma_master_tb.sv
module burst_dma_master_tb_top;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [ADDR_W-1:0] wr_cmd_addr = '0;
  logic [CNT_W-1:0]  wr_cmd_len = '0;
  logic              wr_cmd_valid = 1'b0;
  logic              wr_cmd_ready;
  logic [DATA_W-1:0] wr_in_data = '0;
  logic              wr_in_valid = 1'b0;
  logic              wr_in_ready;
  logic [ADDR_W-1:0] rd_cmd_addr = '0;
  logic [CNT_W-1:0]  rd_cmd_len = '0;
  logic              rd_cmd_valid = 1'b0;
  logic              rd_cmd_ready;
  logic [DATA_W-1:0] rd_out_data;
  logic              rd_out_last;
  logic              rd_out_valid;
  logic              rd_out_ready = 1'b0;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0]        m_awlen;
  logic [2:0]        m_awsize;
  logic [1:0]        m_awburst;
  logic              m_awvalid;
  logic              m_awready = 1'b0;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W/8-1:0] m_wstrb;
  logic              m_wlast;
  logic              m_wvalid;
  logic              m_wready = 1'b0;
  logic              m_bvalid = 1'b0;
  logic              m_bready;
  logic [ADDR_W-1:0] m_araddr;
  logic [7:0]        m_arlen;
  logic [2:0]        m_arsize;
  logic [1:0]        m_arburst;
  logic              m_arvalid;
  logic              m_arready = 1'b0;
  logic [DATA_W-1:0] m_rdata = '0;
  logic              m_rvalid = 1'b0;
  logic              m_rready;

  burst_dma_master #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) dut_i (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit stall_on = 1'b0;

  // Scoreboard queues
  logic [DATA_W-1:0] src_q[$];
  logic [DATA_W:0]   exp_w_q[$];
  logic [39:0]       exp_aw_q[$];
  logic [39:0]       exp_ar_q[$];
  logic [DATA_W-1:0] rbeat_q[$];
  logic [DATA_W:0]   exp_r_q[$];

  int aw_cnt = 0, wl_cnt = 0, b_cnt = 0, ar_cnt = 0;
  int wr_issued = 0, rd_issued = 0;
  bit in_fire = 1'b0, b_fire = 1'b0, r_fire = 1'b0;
  bit chk_wr_ready = 1'b0, chk_rd_ready = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pat(input int m, input int k);
    return !stall_on || ((cyc % m) != k);
  endfunction

  function automatic logic [DATA_W-1:0] gen_w(input logic [ADDR_W-1:0] a, input int i);
    return {32'h5EED_0000 + 32'(i), a ^ 32'(i)};
  endfunction

  function automatic logic [DATA_W-1:0] gen_r(input logic [ADDR_W-1:0] a, input int i);
    return {~a, a + 32'(i * 8)};
  endfunction

  always @(negedge clk) cyc++;

  // Input stream source
  always begin
    @(negedge clk);
    if (in_fire) void'(src_q.pop_front());
    if (!wr_in_valid || in_fire) wr_in_valid = (src_q.size() > 0) && pat(5, 0);
    wr_in_data = (src_q.size() > 0) ? src_q[0] : '0;
    #1;
    in_fire = wr_in_valid && wr_in_ready;
  end

  // Write-side memory model and monitor
  always begin
    @(negedge clk);
    if (b_fire) m_bvalid = 1'b0;
    m_awready = pat(3, 1);
    m_wready  = pat(4, 2);
    if (!m_bvalid && (aw_cnt > b_cnt) && (wl_cnt > b_cnt)) m_bvalid = 1'b1;
    #1;
    if (chk_wr_ready) begin
      chk(wr_cmd_ready, "R5 ready after response", 64'(wr_cmd_ready), 1);
      chk_wr_ready = 1'b0;
    end
    if (m_awvalid && m_awready) begin
      aw_cnt++;
      if (exp_aw_q.size() == 0) begin
        chk(1'b0, "R2 unexpected write address beat", 64'(m_awaddr), 0);
      end else begin
        logic [39:0] e;
        e = exp_aw_q.pop_front();
        chk(m_awaddr == e[39:8], "R3 awaddr", 64'(m_awaddr), 64'(e[39:8]));
        chk(m_awlen == e[7:0], "R3 awlen", 64'(m_awlen), 64'(e[7:0]));
        chk(m_awsize == 3'd3 && m_awburst == 2'b01, "R3 awsize/awburst",
            64'({m_awsize, m_awburst}), 64'({3'd3, 2'b01}));
      end
    end
    if (m_wvalid && m_wready) begin
      if (m_wlast) wl_cnt++;
      if (exp_w_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write beat", m_wdata, 0);
      end else begin
        logic [DATA_W:0] e;
        e = exp_w_q.pop_front();
        chk({m_wlast, m_wdata} == e, "R4 write beat", 64'(m_wdata) ^ {63'd0, m_wlast}, e[63:0] ^ {63'd0, e[64]});
        chk(m_wstrb == '1, "R4 wstrb", 64'(m_wstrb), 64'hFF);
      end
    end
    b_fire = m_bvalid && m_bready;
    if (b_fire) begin
      chk(!wr_cmd_ready, "R5 ready low before response", 64'(wr_cmd_ready), 0);
      b_cnt++;
      chk_wr_ready = 1'b1;
    end
  end

  // Read-side memory model
  always begin
    @(negedge clk);
    if (r_fire) void'(rbeat_q.pop_front());
    m_arready = pat(2, 0);
    if (!m_rvalid || r_fire) m_rvalid = (rbeat_q.size() > 0) && pat(3, 0);
    m_rdata = (rbeat_q.size() > 0) ? rbeat_q[0] : '0;
    #1;
    if (m_arvalid && m_arready) begin
      ar_cnt++;
      if (exp_ar_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read address beat", 64'(m_araddr), 0);
      end else begin
        logic [39:0] e;
        e = exp_ar_q.pop_front();
        chk(m_araddr == e[39:8], "R6 araddr", 64'(m_araddr), 64'(e[39:8]));
        chk(m_arlen == e[7:0], "R6 arlen", 64'(m_arlen), 64'(e[7:0]));
        chk(m_arsize == 3'd3 && m_arburst == 2'b01, "R6 arsize/arburst",
            64'({m_arsize, m_arburst}), 64'({3'd3, 2'b01}));
      end
      for (int i = 0; i <= int'(m_arlen); i++) rbeat_q.push_back(gen_r(m_araddr, i));
    end
    r_fire = m_rvalid && m_rready;
  end

  // Output stream monitor
  always begin
    @(negedge clk);
    rd_out_ready = pat(4, 1);
    #1;
    if (chk_rd_ready) begin
      chk(rd_cmd_ready, "R8 ready after final beat", 64'(rd_cmd_ready), 1);
      chk_rd_ready = 1'b0;
    end
    if (rd_out_valid && rd_out_ready) begin
      if (exp_r_q.size() == 0) begin
        chk(1'b0, "R7 unexpected output beat", rd_out_data, 0);
      end else begin
        logic [DATA_W:0] e;
        e = exp_r_q.pop_front();
        chk({rd_out_last, rd_out_data} == e, "R7 output beat",
            rd_out_data ^ {63'd0, rd_out_last}, e[63:0] ^ {63'd0, e[64]});
        if (rd_out_last) begin
          chk(!rd_cmd_ready, "R8 ready low before final beat", 64'(rd_cmd_ready), 0);
          chk_rd_ready = 1'b1;
        end
      end
    end
  end

  task automatic wr_issue(input logic [ADDR_W-1:0] a, input int len);
    exp_aw_q.push_back({a, 8'(len)});
    for (int i = 0; i <= len; i++) begin
      src_q.push_back(gen_w(a, i));
      exp_w_q.push_back({(i == len), gen_w(a, i)});
    end
    wr_issued++;
    @(negedge clk);
    wr_cmd_addr = a;
    wr_cmd_len = CNT_W'(len);
    wr_cmd_valid = 1'b1;
    #1;
    while (!wr_cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_cmd_valid = 1'b0;
    #1;
    chk(!wr_cmd_ready, "R2 store busy after accept", 64'(wr_cmd_ready), 0);
  endtask

  task automatic wr_wait();
    while (!wr_cmd_ready) begin @(negedge clk); #1; end
    chk(exp_w_q.size() == 0, "R4 all beats written", 64'(exp_w_q.size()), 0);
    chk(b_cnt == wr_issued, "R5 response per burst", 64'(b_cnt), 64'(wr_issued));
  endtask

  task automatic rd_issue(input logic [ADDR_W-1:0] a, input int len);
    exp_ar_q.push_back({a, 8'(len)});
    for (int i = 0; i <= len; i++) exp_r_q.push_back({(i == len), gen_r(a, i)});
    rd_issued++;
    @(negedge clk);
    rd_cmd_addr = a;
    rd_cmd_len = CNT_W'(len);
    rd_cmd_valid = 1'b1;
    #1;
    while (!rd_cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_cmd_valid = 1'b0;
    #1;
    chk(!rd_cmd_ready, "R2 fetch busy after accept", 64'(rd_cmd_ready), 0);
  endtask

  task automatic rd_wait();
    while (!rd_cmd_ready) begin @(negedge clk); #1; end
    chk(exp_r_q.size() == 0, "R7 all beats delivered", 64'(exp_r_q.size()), 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(wr_cmd_ready && rd_cmd_ready, "R1 ready in reset", 64'({wr_cmd_ready, rd_cmd_ready}), 64'b11);
    chk(!m_awvalid && !m_wvalid && !m_bready && !m_arvalid && !m_rready && !rd_out_valid,
        "R1 channels quiet in reset",
        64'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, rd_out_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Basic store and fetch, no stalls
    wr_issue(32'h0000_1000, 3);
    wr_wait();
    rd_issue(32'h0000_2000, 5);
    rd_wait();

    // R10 single-beat bursts
    wr_issue(32'h0000_1100, 0);
    wr_wait();
    rd_issue(32'h0000_2100, 0);
    rd_wait();

    // Stalls on every channel
    stall_on = 1'b1;
    wr_issue(32'h0000_3000, 15);
    wr_wait();
    rd_issue(32'h0000_4000, 15);
    rd_wait();
    stall_on = 1'b0;

    // R2 requests while busy are ignored
    wr_issue(32'h0000_5000, 15);
    for (int k = 0; k < 3; k++) begin
      wr_cmd_addr = 32'h0DEA_D000;
      wr_cmd_len = CNT_W'(2);
      wr_cmd_valid = 1'b1;
      @(negedge clk);
    end
    wr_cmd_valid = 1'b0;
    wr_wait();
    rd_issue(32'h0000_6000, 15);
    for (int k = 0; k < 3; k++) begin
      rd_cmd_addr = 32'h0BAD_0000;
      rd_cmd_len = CNT_W'(2);
      rd_cmd_valid = 1'b1;
      @(negedge clk);
    end
    rd_cmd_valid = 1'b0;
    rd_wait();

    // R9 both halves in flight together, with stalls
    stall_on = 1'b1;
    fork
      wr_issue(32'h0000_7000, 31);
      rd_issue(32'h0000_8000, 31);
    join
    chk(!wr_cmd_ready && !rd_cmd_ready, "R9 both halves busy together",
        64'({wr_cmd_ready, rd_cmd_ready}), 0);
    fork
      wr_wait();
      rd_wait();
    join
    stall_on = 1'b0;

    // R10 largest burst
    fork
      wr_issue(32'h0000_9000, 255);
      rd_issue(32'h0000_A000, 255);
    join
    fork
      wr_wait();
      rd_wait();
    join

    repeat (20) @(negedge clk);
    #1;
    chk(aw_cnt == wr_issued, "R2 store address beats", 64'(aw_cnt), 64'(wr_issued));
    chk(ar_cnt == rd_issued, "R2 fetch address beats", 64'(ar_cnt), 64'(rd_issued));
    chk(src_q.size() == 0, "R4 input stream drained", 64'(src_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule